// File: doc/BRIEF.md
# Dual Interrupt Controller Register Interface

This block is the software-facing side of two cascaded 8-input interrupt controllers on a byte-wide I/O bus. Each controller has a command port and a data port. The block decodes byte writes to those ports and keeps the state that software programs: the interrupt mask, the vector base, the automatic end-of-interrupt option, special mode and the read-back selection. Read cycles return the request register, the in-service register or the mask of the addressed controller.

Command bytes are decoded as whole byte values. An initialization command fixes how many data words follow it, and the block steps through that sequence. End-of-interrupt commands produce one-cycle strobes for the priority logic. When the command calls for it, a strobe also names the in-service input that must be cleared. The request and in-service bits come from the priority logic as inputs, along with the index of the input now being serviced. Arbitration and the acknowledge cycle are handled outside this block.

Top module: `irq_pair_regif`

## Requirements
- R1: After reset, the mask is 0xFC on the primary controller and 0xFE on the secondary (only inputs 0, 1 and 8 enabled). The vector bases are 0x08 and 0x70. Auto-EOI, special mode and the error flags are 0, and command-port reads return the request register.
- R2: The primary controller uses command address 0x20 and data address 0x21. The secondary uses 0xA0 and 0xA1 and owns inputs 8 to 15. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R3: Command 0x10 makes the next two data writes initialization words. Command 0x11 makes it three. In the third word, bit 1 sets auto-EOI (`auto_eoi_o`). The second word is ignored. Mask writes resume only after the last word.
- R4: The first initialization word sets that controller's vector base (`vbase_o` byte) to word & 0xF8. Input i then uses base + i.
- R5: A data-port write outside an initialization sequence loads the 8-bit mask, where bit i masks input i. A data-port read returns the mask. Register updates are visible on the outputs from the clock edge that accepts the write.
- R6: Command 0x0A selects request read-back and command 0x0B selects in-service read-back. A command-port read returns the chosen 8-bit slice of `req_i` or `isr_i`. Each controller keeps its own selection.
- R7: Command 0x68 sets special mode and leaves the selection alone. Command 0x6B sets special mode and selects in-service. Command 0x4A clears special mode and selects request.
- R8: Commands 0x20 to 0x27 pulse `eoi_o` for that controller for one cycle. They also pulse `isr_clr_o`, with `isr_clr_idx_o` equal to `act_idx_i`, when `act_valid_i` is set and `act_idx_i` is below 8 on the primary or below 16 on the secondary.
- R9: Commands 0x60 to 0x67 pulse `eoi_o`. They pulse `isr_clr_o` only when `act_valid_i` is set and `act_idx_i` equals 8*controller + (command & 7).
- R10: Commands 0xC0 to 0xC7 are accepted and change nothing. Any other unlisted byte sets that controller's sticky bit in `err_o` and changes no other state.
- R11: `bus_rdata_o` is loaded at the clock edge where `bus_rd_i` is high and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | 8 | I/O address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| req_i | input | 16 | Request register bits from the priority logic |
| isr_i | input | 16 | In-service register bits from the priority logic |
| act_valid_i | input | 1 | An input is currently being serviced |
| act_idx_i | input | 4 | Index of the input being serviced |
| mask_o | output | 16 | Mask bits, [7:0] primary, [15:8] secondary |
| vbase_o | output | 16 | Vector bases, [7:0] primary, [15:8] secondary |
| auto_eoi_o | output | 2 | Auto-EOI option per controller |
| special_o | output | 2 | Special mode per controller |
| eoi_o | output | 2 | End-of-interrupt strobe per controller |
| isr_clr_o | output | 1 | Strobe to clear one in-service bit |
| isr_clr_idx_o | output | 4 | Input whose in-service bit is cleared |
| err_o | output | 2 | Sticky unknown-command flag per controller |

## Verification
Every write result is registered. Mask, vector base, mode, special mode and error flags therefore change at the first rising edge that samples `bus_wr_i`. The EOI and clear strobes are high only for the cycle that follows that edge. Read data also appears one edge after `bus_rd_i`. The bench drives each access on a falling edge and samples at the next falling edge. This reads each strobe inside its single valid cycle, and a separate idle-cycle check confirms the strobes drop.

// File: rtl/irq_regif_pkg.sv
package irq_regif_pkg;
  localparam int unsigned NUM_CTL = 2;
  localparam int unsigned CTL_INPUTS = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W = $clog2(NUM_CTL * CTL_INPUTS);

  typedef enum logic [3:0] {
    CK_SEL_REQ, CK_SEL_ISR, CK_INIT_SHORT, CK_INIT_LONG,
    CK_EOI_ANY, CK_EOI_ONE, CK_SPC_OFF, CK_SPC_ON, CK_SPC_ISR,
    CK_PRIO, CK_BAD
  } cmd_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_CASC, ST_MODE} init_step_e;

  function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
    cmd_kind_e k;
    case (b)
      8'h0A:   k = CK_SEL_REQ;
      8'h0B:   k = CK_SEL_ISR;
      8'h10:   k = CK_INIT_SHORT;
      8'h11:   k = CK_INIT_LONG;
      8'h4A:   k = CK_SPC_OFF;
      8'h68:   k = CK_SPC_ON;
      8'h6B:   k = CK_SPC_ISR;
      default: begin
        if (b[7:3] == 5'b00100)      k = CK_EOI_ANY;
        else if (b[7:3] == 5'b01100) k = CK_EOI_ONE;
        else if (b[7:3] == 5'b11000) k = CK_PRIO;
        else                         k = CK_BAD;
      end
    endcase
    return k;
  endfunction
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_regif_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_kind_e         kind_o,
  output logic [2:0]        lvl_o
);
  assign kind_o = classify(byte_i);
  assign lvl_o  = byte_i[2:0];
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_regif_pkg::*;
#(
  parameter int unsigned       CTL_IDX  = 0,
  parameter logic [BYTE_W-1:0] RST_MASK = 8'hFC,
  parameter logic [BYTE_W-1:0] RST_VEC  = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  cmd_kind_e         kind_i,
  input  logic [2:0]        lvl_i,
  input  logic              act_valid_i,
  input  logic [IDX_W-1:0]  act_idx_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic [BYTE_W-1:0] vbase_o,
  output logic              auto_eoi_o,
  output logic              special_o,
  output logic              sel_isr_o,
  output logic              err_o,
  output logic              eoi_o,
  output logic              clr_o,
  output logic [IDX_W-1:0]  clr_idx_o
);
  localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'((CTL_IDX + 1) * CTL_INPUTS);
  localparam logic [IDX_W-1:0] BASE  = IDX_W'(CTL_IDX * CTL_INPUTS);

  init_step_e step_q;
  logic       long_q;
  logic       hit_any, hit_one;

  assign hit_any = act_valid_i && ({1'b0, act_idx_i} < LIMIT);
  assign hit_one = act_valid_i && (act_idx_i == (BASE + IDX_W'(lvl_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= ST_IDLE;
      long_q     <= 1'b0;
      mask_o     <= RST_MASK;
      vbase_o    <= RST_VEC;
      auto_eoi_o <= 1'b0;
      special_o  <= 1'b0;
      sel_isr_o  <= 1'b0;
      err_o      <= 1'b0;
      eoi_o      <= 1'b0;
      clr_o      <= 1'b0;
      clr_idx_o  <= '0;
    end else begin
      eoi_o <= 1'b0;
      clr_o <= 1'b0;
      if (data_we_i) begin
        unique case (step_q)
          ST_IDLE: mask_o <= wdata_i;
          ST_VEC: begin
            vbase_o <= wdata_i & 8'hF8;
            step_q  <= ST_CASC;
          end
          ST_CASC: step_q <= long_q ? ST_MODE : ST_IDLE;
          ST_MODE: begin
            auto_eoi_o <= wdata_i[1];
            step_q     <= ST_IDLE;
          end
        endcase
      end
      if (cmd_we_i) begin
        unique case (kind_i)
          CK_SEL_REQ: sel_isr_o <= 1'b0;
          CK_SEL_ISR: sel_isr_o <= 1'b1;
          CK_INIT_SHORT: begin step_q <= ST_VEC; long_q <= 1'b0; end
          CK_INIT_LONG:  begin step_q <= ST_VEC; long_q <= 1'b1; end
          CK_SPC_OFF: begin special_o <= 1'b0; sel_isr_o <= 1'b0; end
          CK_SPC_ON:  special_o <= 1'b1;
          CK_SPC_ISR: begin special_o <= 1'b1; sel_isr_o <= 1'b1; end
          CK_EOI_ANY: begin
            eoi_o     <= 1'b1;
            clr_o     <= hit_any;
            clr_idx_o <= act_idx_i;
          end
          CK_EOI_ONE: begin
            eoi_o     <= 1'b1;
            clr_o     <= hit_one;
            clr_idx_o <= act_idx_i;
          end
          CK_PRIO: ;
          default: err_o <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_pair_regif.sv
module irq_pair_regif
  import irq_regif_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PRI_CMD_ADDR = 8'h20,
  parameter logic [BYTE_W-1:0] SEC_CMD_ADDR = 8'hA0,
  parameter logic [BYTE_W-1:0] PRI_RST_MASK = 8'hFC,
  parameter logic [BYTE_W-1:0] SEC_RST_MASK = 8'hFE,
  parameter logic [BYTE_W-1:0] PRI_RST_VEC  = 8'h08,
  parameter logic [BYTE_W-1:0] SEC_RST_VEC  = 8'h70
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_wr_i,
  input  logic                           bus_rd_i,
  input  logic [BYTE_W-1:0]              bus_addr_i,
  input  logic [BYTE_W-1:0]              bus_wdata_i,
  output logic [BYTE_W-1:0]              bus_rdata_o,
  input  logic [NUM_CTL*CTL_INPUTS-1:0]  req_i,
  input  logic [NUM_CTL*CTL_INPUTS-1:0]  isr_i,
  input  logic                           act_valid_i,
  input  logic [IDX_W-1:0]               act_idx_i,
  output logic [NUM_CTL*CTL_INPUTS-1:0]  mask_o,
  output logic [NUM_CTL*BYTE_W-1:0]      vbase_o,
  output logic [NUM_CTL-1:0]             auto_eoi_o,
  output logic [NUM_CTL-1:0]             special_o,
  output logic [NUM_CTL-1:0]             eoi_o,
  output logic                           isr_clr_o,
  output logic [IDX_W-1:0]               isr_clr_idx_o,
  output logic [NUM_CTL-1:0]             err_o
);
  cmd_kind_e        kind;
  logic [2:0]       lvl;
  logic [NUM_CTL-1:0] sel_isr, clr, hit_cmd, hit_data;
  logic [IDX_W-1:0] clr_idx [NUM_CTL];
  logic [BYTE_W-1:0] rd_mux;

  irq_cmd_decode i_dec (
    .byte_i (bus_wdata_i),
    .kind_o (kind),
    .lvl_o  (lvl)
  );

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    localparam logic [BYTE_W-1:0] CA = (c == 0) ? PRI_CMD_ADDR : SEC_CMD_ADDR;
    assign hit_cmd[c]  = bus_addr_i == CA;
    assign hit_data[c] = bus_addr_i == CA + 8'd1;

    irq_ctl_regs #(
      .CTL_IDX  (c),
      .RST_MASK ((c == 0) ? PRI_RST_MASK : SEC_RST_MASK),
      .RST_VEC  ((c == 0) ? PRI_RST_VEC : SEC_RST_VEC)
    ) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_we_i    (bus_wr_i && hit_cmd[c]),
      .data_we_i   (bus_wr_i && hit_data[c]),
      .wdata_i     (bus_wdata_i),
      .kind_i      (kind),
      .lvl_i       (lvl),
      .act_valid_i (act_valid_i),
      .act_idx_i   (act_idx_i),
      .mask_o      (mask_o[c*CTL_INPUTS +: CTL_INPUTS]),
      .vbase_o     (vbase_o[c*BYTE_W +: BYTE_W]),
      .auto_eoi_o  (auto_eoi_o[c]),
      .special_o   (special_o[c]),
      .sel_isr_o   (sel_isr[c]),
      .err_o       (err_o[c]),
      .eoi_o       (eoi_o[c]),
      .clr_o       (clr[c]),
      .clr_idx_o   (clr_idx[c])
    );
  end

  always_comb begin
    rd_mux        = '0;
    isr_clr_o     = 1'b0;
    isr_clr_idx_o = '0;
    for (int c = 0; c < NUM_CTL; c++) begin
      if (hit_cmd[c])
        rd_mux = sel_isr[c] ? isr_i[c*CTL_INPUTS +: CTL_INPUTS]
                            : req_i[c*CTL_INPUTS +: CTL_INPUTS];
      if (hit_data[c]) rd_mux = mask_o[c*CTL_INPUTS +: CTL_INPUTS];
      if (clr[c]) begin
        isr_clr_o     = 1'b1;
        isr_clr_idx_o = clr_idx[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_pair_regif_chk.sv
module irq_pair_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [7:0]  bus_wdata_i,
  input logic [7:0]  bus_rdata_o,
  input logic        act_valid_i,
  input logic [3:0]  act_idx_i,
  input logic [15:0] mask_o,
  input logic [1:0]  eoi_o,
  input logic        isr_clr_o,
  input logic [3:0]  isr_clr_idx_o,
  input logic [1:0]  err_o
);
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |=> $stable(mask_o));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'b00) |=> ((err_o & $past(err_o)) == $past(err_o)));

  p_eoi_from_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o != 2'b00) |-> ($past(bus_wr_i) && (($past(bus_wdata_i) & 8'hB8) == 8'h20)));

  p_eoi_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eoi_o));

  p_clr_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_clr_o |-> ($past(act_valid_i) && (isr_clr_idx_o == $past(act_idx_i)) && (eoi_o != 2'b00)));
endmodule

bind irq_pair_regif irq_pair_regif_chk i_chk (.*);

// File: tb/test_irq_pair_regif.sv
`timescale 1ns/1ps
module test_irq_pair_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic [15:0] req = 16'h5A3C, isr = 16'h81C3;
  logic        act_valid = 1'b0;
  logic [3:0]  act_idx = '0;
  logic [15:0] mask, vbase;
  logic [1:0]  auto_eoi, special, eoi, err;
  logic        clr;
  logic [3:0]  clr_idx;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_pair_regif i_irq_pair_regif (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_i(req), .isr_i(isr), .act_valid_i(act_valid), .act_idx_i(act_idx),
    .mask_o(mask), .vbase_o(vbase), .auto_eoi_o(auto_eoi), .special_o(special),
    .eoi_o(eoi), .isr_clr_o(clr), .isr_clr_idx_o(clr_idx), .err_o(err)
  );

  // [20] 1=read-check 0=write, [19:12] addr, [11:4] data or expected, [3:0] requirement
  localparam int NV = 29;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h21, 8'hFC, 4'd1},  // R1
    {1'b1, 8'hA1, 8'hFE, 4'd1},
    {1'b1, 8'h20, 8'h3C, 4'd6},  // R6
    {1'b1, 8'hA0, 8'h5A, 4'd6},
    {1'b0, 8'h20, 8'h0B, 4'd6},
    {1'b1, 8'h20, 8'hC3, 4'd6},
    {1'b1, 8'hA0, 8'h5A, 4'd6},
    {1'b0, 8'h20, 8'h0A, 4'd6},
    {1'b1, 8'h20, 8'h3C, 4'd6},
    {1'b0, 8'h21, 8'h5A, 4'd5},  // R5
    {1'b1, 8'h21, 8'h5A, 4'd5},
    {1'b1, 8'hA1, 8'hFE, 4'd5},
    {1'b0, 8'h55, 8'h12, 4'd2},  // R2
    {1'b1, 8'h21, 8'h5A, 4'd2},
    {1'b1, 8'hA1, 8'hFE, 4'd2},
    {1'b1, 8'h55, 8'h00, 4'd2},
    {1'b0, 8'hA0, 8'h11, 4'd3},  // R3
    {1'b0, 8'hA1, 8'h7D, 4'd3},
    {1'b0, 8'hA1, 8'hFF, 4'd3},
    {1'b1, 8'hA1, 8'hFE, 4'd3},
    {1'b0, 8'hA1, 8'h02, 4'd3},
    {1'b0, 8'hA1, 8'h33, 4'd3},
    {1'b1, 8'hA1, 8'h33, 4'd3},
    {1'b1, 8'h21, 8'h5A, 4'd3},
    {1'b0, 8'h20, 8'h10, 4'd3},
    {1'b0, 8'h21, 8'h45, 4'd3},
    {1'b0, 8'h21, 8'h00, 4'd3},
    {1'b0, 8'h21, 8'h0F, 4'd3},
    {1'b1, 8'h21, 8'h0F, 4'd3}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(tag, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask, 16'hFEFC);
    chk("R1 vbase", vbase, 16'h7008);
    chk("R1 auto_eoi", {14'd0, auto_eoi}, 16'd0);
    chk("R1 special", {14'd0, special}, 16'd0);
    chk("R1 err", {14'd0, err}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20])
        bus_read(VEC[i][19:12], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else
        bus_write(VEC[i][19:12], VEC[i][11:4]);
    end

    // R4 vector bases from first init word; R3 mode word only in long sequence
    chk("R4 vbase", vbase, 16'h7840);
    chk("R3 auto_eoi", {14'd0, auto_eoi}, 16'h0002);

    // R7 special mode
    bus_write(8'h20, 8'h68);
    chk("R7 special on", {14'd0, special}, 16'h0001);
    bus_read(8'h20, 8'h3C, "R7 select kept");
    bus_write(8'h20, 8'h6B);
    bus_read(8'h20, 8'hC3, "R7 6B selects isr");
    bus_write(8'h20, 8'h4A);
    chk("R7 special off", {14'd0, special}, 16'h0000);
    bus_read(8'h20, 8'h3C, "R7 4A selects req");
    bus_write(8'hA0, 8'h6B);
    chk("R7 secondary special", {14'd0, special}, 16'h0002);
    bus_read(8'hA0, 8'h81, "R7 secondary isr");

    // R9 specific EOI
    act_valid = 1'b1; act_idx = 4'd5;
    bus_write(8'h20, 8'h63);
    chk("R9 eoi other level", {13'd0, eoi, clr}, {13'd0, 2'b01, 1'b0});
    bus_write(8'h20, 8'h65);
    chk("R9 eoi matching level", {11'd0, eoi, clr, clr_idx}, {11'd0, 2'b01, 1'b1, 4'd5});
    @(negedge clk);
    chk("R9 strobes drop", {13'd0, eoi, clr}, 16'd0);
    bus_write(8'hA0, 8'h65);
    chk("R9 secondary names 13", {13'd0, eoi, clr}, {13'd0, 2'b10, 1'b0});

    // R8 non-specific EOI
    act_idx = 4'd13;
    bus_write(8'hA0, 8'h21);
    chk("R8 secondary clears 13", {11'd0, eoi, clr, clr_idx}, {11'd0, 2'b10, 1'b1, 4'd13});
    bus_write(8'h20, 8'h20);
    chk("R8 primary ignores 13", {13'd0, eoi, clr}, {13'd0, 2'b01, 1'b0});
    act_valid = 1'b0; act_idx = 4'd3;
    bus_write(8'h20, 8'h27);
    chk("R8 nothing in service", {13'd0, eoi, clr}, {13'd0, 2'b01, 1'b0});

    // R10 ignored and unknown commands
    bus_write(8'h20, 8'hC5);
    chk("R10 prio cmd no err", {14'd0, err}, 16'd0);
    bus_read(8'h21, 8'h0F, "R10 prio cmd mask kept");
    bus_write(8'h20, 8'h55);
    chk("R10 bad cmd err", {14'd0, err}, 16'h0001);
    chk("R10 bad cmd special kept", {14'd0, special}, 16'h0002);
    bus_read(8'h20, 8'h3C, "R10 bad cmd select kept");
    bus_read(8'h21, 8'h0F, "R10 bad cmd mask kept");
    bus_write(8'h20, 8'h0B);
    chk("R10 err sticky", {14'd0, err}, 16'h0001);
    bus_read(8'h20, 8'hC3, "R10 later cmd works");

    // R11 read data holds without a read
    req = 16'h0000; isr = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", {8'h00, rdata}, 16'h00C3);
    bus_read(8'h20, 8'h00, "R11 fresh read");

    finish_run();
  end
endmodule